// File: doc/BRIEF.md
# ADC Power Sequencer

This controller drives the three power lines of an analog-to-digital converter: bandgap, reference and converter core. It also drives the enable for the converter's clock gate. A power-up request brings the converter to the operational state. It can do this in two ways. The staged way enables the bandgap and reference first and enables the core once the bandgap has settled. The simultaneous way enables all three rails together and waits the bandgap settle time once. A power-down request, qualified by a 2-bit mode select, walks the rails down to one of three low-power levels.

Delays are counted in clock cycles and derived from the `CLK_HZ` parameter. The bandgap settle time is 5 ms. The core settle time is `PWD_US` microseconds, with a default of 1000 µs, the worst case. Conversion requests arrive on a valid/ready pair. `conv_ready` is high only in the operational state. The interface never back-pressures: a request is taken in every cycle that `conv_valid` is high. If `conv_ready` is high in that cycle, the request is forwarded as a one-cycle `conv_start`. Otherwise it is dropped, not queued, and a one-cycle `conv_err` pulse is raised.

Top module: `adc_pwr_seq`

## Requirements
- R1: `core_en` is never high while `bg_en` or `ref_en` is low.
- R2: Staged power-up from the off or deep level works as follows. In the cycle after the request, `adc_clk_en`, `bg_en` and `ref_en` are high and `core_en` is low. `core_en` rises exactly BGR = CLK_HZ/200 cycles later.
- R3: After `core_en` rises in a staged power-up, `conv_ready` rises exactly PWD = CLK_HZ·PWD_US/10^6 cycles later.
- R4: With `simul_en` high, power-up from the off or deep level raises all three rails in the cycle after the request. `conv_ready` rises BGR cycles after that.
- R5: While `conv_ready` is high, `adc_clk_en`, `bg_en`, `ref_en` and `core_en` are all high.
- R6: A cycle with `conv_valid` high and `conv_ready` low gives `conv_err`=1 and `conv_start`=0 in the next cycle. The request is not replayed later.
- R7: A cycle with `conv_valid` and `conv_ready` both high gives `conv_start`=1 and `conv_err`=0 in the next cycle.
- R8: Each level has a fixed rail pattern {clk, bg, ref, core}:
  - Reset and off (`dn_mode`=2'b11): 0000.
  - Deep (2'b10): 1000.
  - Standby (2'b01): 1110.
- R9: A power-down request from the ready state lowers the rails one step per cycle, in this order: `conv_ready` first, then `core_en`, then `bg_en`/`ref_en`, then `adc_clk_en`. The walk stops at the level `dn_mode` selects.
- R10: A power-up request that arrives during a power-down walk is held. Power-up begins in the cycle after the walk reaches its final level.
- R11: Power-up from standby raises `core_en` in the next cycle and `conv_ready` PWD cycles after that.
- R12: A power-down request during the staged bandgap wait drops `bg_en` and `ref_en` in the next cycle. The rails then rest at deep level or below, even when standby was selected.
- R13: The following requests are ignored, and the rails keep their values:
  - a power-down request with `dn_mode`=2'b00;
  - a power-down request to a level no deeper than the current one;
  - a power-up request while `conv_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up_req | input | 1 | One-cycle power-up request |
| pwr_dn_req | input | 1 | One-cycle power-down request |
| dn_mode | input | 2 | Power-down target level: 00 none, 01 standby, 10 deep, 11 off |
| simul_en | input | 1 | Use simultaneous rail enable for the next power-up |
| conv_valid | input | 1 | Conversion request valid |
| conv_ready | output | 1 | Converter ready; conversions are accepted |
| conv_start | output | 1 | One-cycle forwarded conversion start |
| conv_err | output | 1 | One-cycle pulse for a dropped early request |
| adc_clk_en | output | 1 | Converter clock gate enable |
| bg_en | output | 1 | Bandgap powered |
| ref_en | output | 1 | Reference powered |
| core_en | output | 1 | Converter core powered |

## Verification
Power-up is tried from three starting levels: off with staged enable, deep with simultaneous enable, and standby. Each yields a different pair of core-enable and ready offsets, so a swapped delay or a wrong entry state shows up as a misplaced edge. Power-down is tried toward all three targets and with `dn_mode`=00. The full-off walk is checked cycle by cycle to catch ordering faults. Further directed cases cover a power-up request injected mid-walk, an abort during the bandgap wait, and redundant requests. Random conversion requests, and random operations drawn from a fixed seed, run throughout and check the start/error split and the rail invariants in every cycle.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_DEEP, ST_STBY, ST_BGWAIT, ST_SIMWAIT, ST_CORESET, ST_READY, ST_DNRDY
  } pst_t;

  // Depth of a resting level; larger means more powered down.
  typedef enum logic [1:0] {
    LV_RUN  = 2'd0,
    LV_STBY = 2'd1,
    LV_DEEP = 2'd2,
    LV_OFF  = 2'd3
  } lvl_t;

  typedef struct packed {
    logic clk_en;
    logic bg;
    logic vref;
    logic core;
    logic rdy;
  } rails_t;

  function automatic lvl_t lvl_of(pst_t s);
    case (s)
      ST_OFF:  return LV_OFF;
      ST_DEEP: return LV_DEEP;
      ST_STBY: return LV_STBY;
      default: return LV_RUN;
    endcase
  endfunction

  function automatic rails_t rails_of(pst_t s);
    case (s)
      ST_OFF:                           return 5'b00000;
      ST_DEEP:                          return 5'b10000;
      ST_STBY, ST_BGWAIT:               return 5'b11100;
      ST_SIMWAIT, ST_CORESET, ST_DNRDY: return 5'b11110;
      ST_READY:                         return 5'b11111;
      default:                          return 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int unsigned BGR_CYC = 4,
  parameter int unsigned PWD_CYC = 2,
  parameter int unsigned CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          dn_req,
  input  logic [1:0]    dn_mode,
  input  logic          simul,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output rails_t        rails
);

  pst_t   st, nxt;
  lvl_t   tgt, tgt_n;
  logic   pend, pend_n;
  logic   dn_ok;

  always_comb begin
    nxt    = st;
    tgt_n  = tgt;
    pend_n = pend;
    dn_ok  = dn_req && (lvl_t'(dn_mode) > tgt);
    case (st)
      ST_OFF, ST_DEEP, ST_STBY: begin
        if (dn_ok) tgt_n = lvl_t'(dn_mode);
        if (lvl_of(st) < tgt_n) begin
          if (up_req) pend_n = 1'b1;
          nxt = (st == ST_STBY) ? ST_DEEP : ST_OFF;
        end else if (up_req || pend) begin
          pend_n = 1'b0;
          tgt_n  = LV_RUN;
          if (st == ST_STBY) nxt = ST_CORESET;
          else if (simul)    nxt = ST_SIMWAIT;
          else               nxt = ST_BGWAIT;
        end
      end
      ST_BGWAIT: begin
        if (dn_ok) begin
          tgt_n = lvl_t'(dn_mode);
          nxt   = ST_DEEP;
        end else if (tmr_zero) nxt = ST_CORESET;
      end
      ST_SIMWAIT: begin
        if (dn_ok) begin
          tgt_n = lvl_t'(dn_mode);
          nxt   = ST_DEEP;
        end else if (tmr_zero) nxt = ST_READY;
      end
      ST_CORESET: begin
        if (dn_ok) begin
          tgt_n = lvl_t'(dn_mode);
          nxt   = ST_STBY;
        end else if (tmr_zero) nxt = ST_READY;
      end
      ST_READY: begin
        if (dn_ok) begin
          tgt_n = lvl_t'(dn_mode);
          nxt   = ST_DNRDY;
        end
      end
      ST_DNRDY: begin
        if (dn_ok)  tgt_n  = lvl_t'(dn_mode);
        if (up_req) pend_n = 1'b1;
        nxt = ST_STBY;
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign tmr_load = (nxt != st) &&
                    (nxt == ST_BGWAIT || nxt == ST_SIMWAIT || nxt == ST_CORESET);
  assign tmr_val  = (nxt == ST_CORESET) ? CW'(PWD_CYC - 1) : CW'(BGR_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      tgt   <= LV_OFF;
      pend  <= 1'b0;
      rails <= '0;
    end else begin
      st    <= nxt;
      tgt   <= tgt_n;
      pend  <= pend_n;
      rails <= rails_of(nxt);
    end
  end

  // R1
  core_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rails.core |-> (rails.bg && rails.vref));

  // R5
  rdy_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rails.rdy |-> (rails.clk_en && rails.bg && rails.vref && rails.core));

  // R9
  rdy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rails.rdy) |-> rails.core);

  // R9
  core_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rails.core) |-> !$past(rails.rdy));

  // R9
  clk_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rails.clk_en) |-> !$past(rails.bg));

endmodule

// File: rtl/adc_pwr_convgate.sv
module adc_pwr_convgate (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_valid,
  input  logic adc_rdy,
  output logic conv_start,
  output logic conv_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      conv_err   <= 1'b0;
    end else begin
      conv_start <= conv_valid &&  adc_rdy;
      conv_err   <= conv_valid && !adc_rdy;
    end
  end

  // R6
  start_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && conv_err));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned PWD_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up_req,
  input  logic       pwr_dn_req,
  input  logic [1:0] dn_mode,
  input  logic       simul_en,
  input  logic       conv_valid,
  output logic       conv_ready,
  output logic       conv_start,
  output logic       conv_err,
  output logic       adc_clk_en,
  output logic       bg_en,
  output logic       ref_en,
  output logic       core_en
);

  localparam longint unsigned BGR_L = 64'(CLK_HZ) / 64'd200;
  localparam longint unsigned PWD_L = (64'(CLK_HZ) * 64'(PWD_US)) / 64'd1000000;
  localparam int unsigned BGR_CYC   = (BGR_L == 0) ? 1 : 32'(BGR_L);
  localparam int unsigned PWD_CYC   = (PWD_L == 0) ? 1 : 32'(PWD_L);
  localparam int unsigned MAX_CYC   = (BGR_CYC > PWD_CYC) ? BGR_CYC : PWD_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  rails_t        rails;

  adc_pwr_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .val   (tmr_val),
    .zero  (tmr_zero)
  );

  adc_pwr_fsm #(.BGR_CYC(BGR_CYC), .PWD_CYC(PWD_CYC), .CW(CW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req   (pwr_up_req),
    .dn_req   (pwr_dn_req),
    .dn_mode  (dn_mode),
    .simul    (simul_en),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .rails    (rails)
  );

  adc_pwr_convgate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .adc_rdy    (rails.rdy),
    .conv_start (conv_start),
    .conv_err   (conv_err)
  );

  assign conv_ready = rails.rdy;
  assign adc_clk_en = rails.clk_en;
  assign bg_en      = rails.bg;
  assign ref_en     = rails.vref;
  assign core_en    = rails.core;

endmodule

// File: tb/adc_pwr_seq_bench.sv
module adc_pwr_seq_bench;

  localparam int unsigned CLK_HZ = 20000;
  localparam int BGR = CLK_HZ / 200;
  localparam int PWD = (CLK_HZ * 1000) / 1000000;

  localparam int P_OFF  = 5'b00000;
  localparam int P_DEEP = 5'b10000;
  localparam int P_STBY = 5'b11100;
  localparam int P_ALL  = 5'b11110;
  localparam int P_RDY  = 5'b11111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_up_req = 1'b0, pwr_dn_req = 1'b0, simul_en = 1'b0, conv_valid = 1'b0;
  logic [1:0] dn_mode = 2'b00;
  logic conv_ready, conv_start, conv_err, adc_clk_en, bg_en, ref_en, core_en;

  int checks = 0;
  int errors = 0;
  logic pv, pr;

  always #4 clk = ~clk;

  adc_pwr_seq #(.CLK_HZ(CLK_HZ)) u_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
    .dn_mode(dn_mode), .simul_en(simul_en), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_start(conv_start), .conv_err(conv_err),
    .adc_clk_en(adc_clk_en), .bg_en(bg_en), .ref_en(ref_en), .core_en(core_en)
  );

  function automatic int rails();
    return {27'd0, adc_clk_en, bg_en, ref_en, core_en, conv_ready};
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // One cycle: drive conv_valid, advance to the next falling edge, check invariants.
  task automatic step(logic v);
    pv = v;
    pr = conv_ready;
    conv_valid = v;
    @(negedge clk);
    chk("R1", int'(core_en && !(bg_en && ref_en)), 0);
    chk("R5", int'(conv_ready && !(adc_clk_en && bg_en && ref_en && core_en)), 0);
    if (pr) chk("R7", {conv_start, conv_err}, {pv, 1'b0});
    else    chk("R6", {conv_start, conv_err}, {1'b0, pv});
  endtask

  task automatic pulse_up(logic sim);
    simul_en = sim;
    pwr_up_req = 1'b1;
    step(1'b0);
    pwr_up_req = 1'b0;
  endtask

  task automatic pulse_dn(logic [1:0] m);
    dn_mode = m;
    pwr_dn_req = 1'b1;
    step(1'b0);
    pwr_dn_req = 1'b0;
  endtask

  // Current sample is index 1; expects core at core_at and ready at rdy_at.
  task automatic watch_up(int core_at, int rdy_at, string r);
    for (int i = 1; i <= rdy_at + 2; i++) begin
      chk(r, rails(), (i >= rdy_at) ? P_RDY : (i >= core_at) ? P_ALL : P_STBY);
      if (i < rdy_at + 2) step(1'($urandom % 2));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    chk("R8 reset", rails(), P_OFF);
    // R6: early requests dropped while off
    step(1'b1);
    step(1'b0);
    chk("R6 no replay", int'(conv_start), 0);

    // R2 R3: staged from off with random conversion requests
    pulse_up(1'b0);
    watch_up(BGR + 1, BGR + PWD + 1, "R2/R3");

    // R13: redundant requests
    pulse_up(1'b0);
    step(1'b0);
    chk("R13 up at ready", rails(), P_RDY);
    pulse_dn(2'b00);
    step(1'b0);
    chk("R13 dn mode 00", rails(), P_RDY);
    step(1'b1);
    chk("R7 start", int'(conv_start), 1);

    // R8 R9: down to standby
    pulse_dn(2'b01);
    chk("R9 rdy first", rails(), P_ALL);
    step(1'b0);
    chk("R9 core second", rails(), P_STBY);
    repeat (4) step(1'b0);
    chk("R8 standby", rails(), P_STBY);
    pulse_dn(2'b01);
    chk("R13 dn same level", rails(), P_STBY);

    // R11
    pulse_up(1'b0);
    watch_up(1, PWD + 1, "R11");

    // R8 deep
    pulse_dn(2'b10);
    step(1'b0);
    step(1'b0);
    chk("R8 deep entry", rails(), P_DEEP);
    repeat (4) step(1'b0);
    chk("R8 deep rest", rails(), P_DEEP);

    // R4 simultaneous from deep
    pulse_up(1'b1);
    watch_up(1, BGR + 1, "R4");

    // R9 full walk to off
    pulse_dn(2'b11);
    chk("R9 step1", rails(), P_ALL);
    step(1'b0);
    chk("R9 step2", rails(), P_STBY);
    step(1'b0);
    chk("R9 step3", rails(), P_DEEP);
    step(1'b0);
    chk("R9 step4", rails(), P_OFF);
    repeat (4) step(1'b0);
    chk("R8 off rest", rails(), P_OFF);

    // R10: up request held during walk
    pulse_up(1'b0);
    watch_up(BGR + 1, BGR + PWD + 1, "R2/R3");
    pulse_dn(2'b11);
    simul_en = 1'b0;
    pwr_up_req = 1'b1;
    step(1'b0);
    pwr_up_req = 1'b0;
    chk("R10 walk continues", rails(), P_STBY);
    step(1'b0);
    chk("R10 walk deep", rails(), P_DEEP);
    step(1'b0);
    chk("R10 reaches off", rails(), P_OFF);
    step(1'b0);
    watch_up(BGR + 1, BGR + PWD + 1, "R10");

    // R12: abort during bandgap wait
    pulse_dn(2'b11);
    repeat (3) step(1'b0);
    pulse_up(1'b0);
    repeat (9) step(1'b0);
    chk("R12 before abort", rails(), P_STBY);
    pulse_dn(2'b01);
    chk("R12 bg dropped", rails(), P_DEEP);
    repeat (3) step(1'b0);
    chk("R12 rests deep", rails(), P_DEEP);

    // Random operations; invariants and R6/R7 checked in every step
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0)      pulse_up(1'($urandom % 2));
      else if (op == 1) pulse_dn(2'($urandom % 4));
      else              step(1'($urandom % 2));
      if (op < 2) repeat (int'($urandom % 40)) step(1'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule